// File: doc/BRIEF.md
# Prioritized Interrupt Mask Controller

This block collects fourteen interrupt sources into a request register, masks them with an enable register and a global enable bit, and presents the highest pending, enabled priority level as a 3-bit code to the processor. Sources are grouped onto six fixed levels, and several sources share a level.

Software reaches the two registers over a small register bus. Each register has a write address and a separate read-back address. A write either sets or clears the bits selected by its data, depending on data bit 15. This lets software raise requests as well as clear them, without a read-modify-write. Hardware request pulses set request bits, and those bits stay set until software clears them.

Top module: `irq_level_ctrl`

## Requirements
- R1: Reset clears the enable and request registers and drives `ipl_o` to 0.
- R2: A write to address 0 (enable) or address 1 (request) with data bit 15 = 1 sets every register bit whose data bit is 1. With data bit 15 = 0 it clears every register bit whose data bit is 1. Register bits whose data bit is 0 keep their value. For example, 0xC005 to address 0 sets enable bits 0, 2 and 14, and 0x0020 to address 1 clears request bit 5.
- R3: Enable bit 14 is the global enable. While it is 0, `ipl_o` is 0.
- R4: `ipl_o` never shows 7.
- R5: Sources map to levels as follows: bits 0..2 to level 1, bit 3 to level 2, bits 4..6 to level 3, bits 7..10 to level 4, bits 11..12 to level 5, and bit 13 to level 6. `ipl_o` is the highest level that has a bit set in both the request register and the enable register (with the global enable set), and 0 otherwise.
- R6: `ipl_o` is registered. It reflects the register contents one clock after they change, so it appears two clock edges after the write or pulse that causes the change.
- R7: A one-cycle pulse on `src_pulse[i]` sets request bit i, and the bit stays set until software clears it.
- R8: If a hardware pulse and a software clear reach the same request bit in the same cycle, the bit ends up set.
- R9: Reads are combinational. Address 2 returns {0, enable[14:0]}, address 3 returns {00, request[13:0]}, and addresses 0 and 1 return 0. Bit 15 always reads 0, and reads have no side effects.
- R10: Request bit 14 does not exist. Writes to it have no effect, and it reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 14 | Hardware request pulses, one per source |
| bus_addr | input | 2 | Register address: 0 enable write, 1 request write, 2 enable read, 3 request read |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read-back data |
| ipl_o | output | 3 | Priority level presented to the processor |

## Verification
Register contents change at the first clock edge after a write or pulse, so read-back values are due at that edge. `ipl_o` is due one edge later. The bench drives inputs at the falling edge, and a behavioural model advances at each rising edge. The model keeps the level it computed from the register state before that edge, so it reproduces the two-edge latency. Read-back data and `ipl_o` are compared at every falling edge, before the next inputs are driven.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] src_pulse,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_we,
  output logic [15:0] bus_rdata,
  output logic [2:0]  ipl_o
);
  localparam logic [1:0] A_EN_WR  = 2'd0;
  localparam logic [1:0] A_RQ_WR  = 2'd1;
  localparam logic [1:0] A_EN_RD  = 2'd2;
  localparam logic [1:0] A_RQ_RD  = 2'd3;
  localparam int unsigned GEN_BIT = 14;

  localparam logic [13:0] M_L1 = 14'h0007;
  localparam logic [13:0] M_L2 = 14'h0008;
  localparam logic [13:0] M_L3 = 14'h0070;
  localparam logic [13:0] M_L4 = 14'h0780;
  localparam logic [13:0] M_L5 = 14'h1800;
  localparam logic [13:0] M_L6 = 14'h2000;

  logic [14:0] en_q;
  logic [13:0] req_q;
  logic [2:0]  lvl_q, lvl_d;
  logic [13:0] live;

  wire set_op = bus_wdata[15];
  wire en_wr  = bus_we && (bus_addr == A_EN_WR);
  wire rq_wr  = bus_we && (bus_addr == A_RQ_WR);

  wire [14:0] en_set = (en_wr &&  set_op) ? bus_wdata[14:0] : 15'd0;
  wire [14:0] en_clr = (en_wr && !set_op) ? bus_wdata[14:0] : 15'd0;
  wire [13:0] rq_set = (rq_wr &&  set_op) ? bus_wdata[13:0] : 14'd0;
  wire [13:0] rq_clr = (rq_wr && !set_op) ? bus_wdata[13:0] : 14'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      req_q <= '0;
      lvl_q <= '0;
    end else begin
      en_q  <= (en_q & ~en_clr) | en_set;
      req_q <= (req_q & ~rq_clr) | rq_set | src_pulse;
      lvl_q <= lvl_d;
    end
  end

  assign live = req_q & en_q[13:0] & {14{en_q[GEN_BIT]}};

  always_comb begin
    if      (|(live & M_L6)) lvl_d = 3'd6;
    else if (|(live & M_L5)) lvl_d = 3'd5;
    else if (|(live & M_L4)) lvl_d = 3'd4;
    else if (|(live & M_L3)) lvl_d = 3'd3;
    else if (|(live & M_L2)) lvl_d = 3'd2;
    else if (|(live & M_L1)) lvl_d = 3'd1;
    else                     lvl_d = 3'd0;
  end

  assign ipl_o = lvl_q;

  always_comb begin
    case (bus_addr)
      A_EN_RD: bus_rdata = {1'b0, en_q};
      A_RQ_RD: bus_rdata = {2'b00, req_q};
      default: bus_rdata = 16'h0000;
    endcase
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (ipl_o == 3'd0 && en_q == '0 && req_q == '0));
  p_gen_off_r3: assert property (@(posedge clk) disable iff (!rst_n) !en_q[GEN_BIT] |=> ipl_o == 3'd0);
  p_no_seven_r4: assert property (@(posedge clk) disable iff (!rst_n) ipl_o != 3'd7);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((req_q & $past(src_pulse)) == $past(src_pulse)));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr && !set_op) |=> ((req_q & $past(bus_wdata[13:0] & ~src_pulse)) == 14'd0));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |=> ipl_o == 3'd0);
  p_rd_b15_r9: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[15] == 1'b0);
endmodule

// File: tb/sim_irq_level_ctrl.sv
module sim_irq_level_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] src_pulse = '0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 0;
  logic [15:0] bus_rdata;
  logic [2:0]  ipl_o;

  int errors = 0, checks = 0;
  int m_en[15];
  int m_req[14];
  int m_lvl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_level_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
                     .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .ipl_o(ipl_o));

  function automatic int level_of(int b);
    if (b <= 2) return 1;
    if (b == 3) return 2;
    if (b <= 6) return 3;
    if (b <= 10) return 4;
    if (b <= 12) return 5;
    return 6;
  endfunction

  function automatic int model_level();
    int best = 0;
    if (m_en[14] == 0) return 0;
    for (int b = 0; b < 14; b++)
      if (m_req[b] && m_en[b] && level_of(b) > best) best = level_of(b);
    return best;
  endfunction

  function automatic logic [15:0] model_read(logic [1:0] a);
    logic [15:0] v = '0;
    if (a == 2) for (int b = 0; b < 15; b++) v[b] = m_en[b][0];
    if (a == 3) for (int b = 0; b < 14; b++) v[b] = m_req[b][0];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 15; b++) m_en[b] = 0;
      for (int b = 0; b < 14; b++) m_req[b] = 0;
      m_lvl = 0;
    end else begin
      m_lvl = model_level();
      if (bus_we && bus_addr == 0)
        for (int b = 0; b < 15; b++) if (bus_wdata[b]) m_en[b] = bus_wdata[15];
      if (bus_we && bus_addr == 1)
        for (int b = 0; b < 14; b++) if (bus_wdata[b]) m_req[b] = bus_wdata[15];
      for (int b = 0; b < 14; b++) if (src_pulse[b]) m_req[b] = 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R5/R6 level", ipl_o, m_lvl);
    check("R9 readback", bus_rdata, model_read(bus_addr));
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; tick(); bus_we = 0; bus_wdata = 0;
  endtask
  task automatic rd_check(string tag, logic [1:0] a, logic [15:0] exp);
    bus_addr = a; #1; check(tag, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 ipl", ipl_o, 0);
    rst_n = 1;
    rd_check("R1 enable", 2, 16'h0000);
    rd_check("R1 request", 3, 16'h0000);
    wr(0, 16'hC005);
    rd_check("R2 set 0xC005", 2, 16'h4005);
    src_pulse = 14'h0001; tick(); src_pulse = 0;
    rd_check("R7 pulse sets bit", 3, 16'h0001);
    tick(); check("R5 level1", ipl_o, 1);
    wr(0, 16'h8000 | 16'h2008);
    src_pulse = 14'h2008; tick(); src_pulse = 0; tick();
    check("R5 level6 wins", ipl_o, 6);
    wr(0, 16'h4000); tick();
    check("R3 global off", ipl_o, 0);
    wr(0, 16'hC000); tick();
    check("R6 restored", ipl_o, 6);
    wr(1, 16'h2000); tick();
    check("R2 clear bit13", ipl_o, 2);
    wr(1, 16'h8020);
    rd_check("R2 sw raise", 3, 16'h0029);
    bus_addr = 1; bus_wdata = 16'h0008; bus_we = 1; src_pulse = 14'h0008; tick();
    bus_we = 0; src_pulse = 0;
    rd_check("R8 set wins", 3, 16'h0029);
    wr(1, 16'hC000);
    rd_check("R10 bit14 absent", 3, 16'h0029);
    bus_addr = 0; #1; check("R9 write addr reads 0", bus_rdata, 0);
    wr(1, 16'h3FFF); tick();
    check("R4 idle", ipl_o, 0);
    for (int i = 0; i < 3000; i++) begin
      bus_addr = 2'($urandom_range(0, 3));
      bus_we = ($urandom_range(0, 9) < 3);
      bus_wdata = 16'($urandom);
      for (int b = 0; b < 14; b++) src_pulse[b] = ($urandom_range(0, 19) == 0);
      tick();
    end
    bus_we = 0; src_pulse = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule